// File: doc/BRIEF.md
# UART transmitter with break and preamble control

This block serialises bytes onto an asynchronous line. A byte written through the data strobe is held in a one-entry holding register. At a bit boundary the byte moves in parallel into an output shift register, and the shift register drives one frame onto the line. All sequencing advances on a single-cycle bit tick that marks each bit period. Baud generation, parity and interrupts are handled elsewhere.

Two control levels steer the transmitter beyond plain characters. The enable level `tx_en` gates every new frame. A fresh rise of `tx_en` costs one bit time before anything is sent. Dropping `tx_en` briefly and restoring it while a word is on the line queues an idle preamble after that word. The break level `brk_req` sends break words back to back for as long as it is high. A high pulse that has ended queues exactly one break word. Preambles and breaks go out before any byte that is waiting in the holding register. The line driver enable is released only when the transmitter and the receiver are both off and no word is in flight.

Top module: `uart_tx_brk`

## Requirements
- R1: A data frame is one low start bit, the 8 data bits least significant first, then one high stop bit, each held for one bit period that begins at a bit tick. If the holding register is refilled before the frame ends, the next frame follows with no idle bit between them.
- R2: A write strobe makes `hold_empty` low in the following cycle. `hold_empty` returns high in the cycle after the bit tick at which that byte's start bit begins.
- R3: After `tx_en` is seen rising, the line stays high through the first bit tick, and a waiting frame starts at the second bit tick.
- R4: If `tx_en` falls while a word is in flight, that word completes. No new word starts while `tx_en` is low, and a written byte stays waiting (`hold_empty` low).
- R5: A low-then-high pulse on `tx_en` during a word makes 10 high bit periods follow that word, ahead of any waiting byte.
- R6: While `brk_req` is high at word boundaries, break words go out back to back. Each break word is 10 low bit periods followed by 1 high bit period.
- R7: When `brk_req` falls, exactly one more break word is sent after the current word, ahead of any waiting byte.
- R8: `tx_done` is high exactly when no word is in flight and no byte, preamble or break is waiting (`brk_req` low). When `tx_done` is high, the line is high.
- R9: `txd_oe` is low when `tx_en` and `rx_active` are both low and no word is in flight. It is high otherwise.
- R10: After reset, `txd` is high, `hold_empty` is high, `tx_done` is high and `txd_oe` follows R9.
- R11: `txd` changes only in the cycle after a bit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_en | input | 1 | Transmitter enable level |
| brk_req | input | 1 | Send-break request level |
| rx_active | input | 1 | Receiver enabled, keeps the pin driven |
| txd | output | 1 | Serial line, idle high |
| txd_oe | output | 1 | Output-enable for the line driver |
| hold_empty | output | 1 | Holding register free for a new byte |
| tx_done | output | 1 | Nothing in flight or waiting |

## Verification
Random bytes sent back to back check the bit order and the absence of gaps between frames, so a swapped data order or a lost stop bit shows up as a stream mismatch. Directed sequences follow. A cold enable with a byte waiting separates the one-bit start delay from an immediate start. A short enable dip during a word checks that the preamble is inserted ahead of the waiting byte. A short break pulse and a long break hold are compared on the number of break words they produce: exactly one after a release, versus repeated words while held. Dropping the enable for good shows that the current word completes and the next byte is held back, and it also exercises the driver-enable release.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = DATA_W + 2,
  localparam int BRK_BITS = DATA_W + 3,
  localparam int CW = $clog2(BRK_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              rx_active,
  output logic              txd,
  output logic              txd_oe,
  output logic              hold_empty,
  output logic              tx_done
);

  logic [DATA_W-1:0]   hold_q;
  logic                hold_full;
  logic                te_q, brk_q, dly_q;
  logic                pre_pend, brk_pend;
  logic                busy;
  logic [BRK_BITS-1:0] sh_q;
  logic [CW-1:0]       cnt_q;

  logic te_rise, brk_fall, last_bit, slot_free, go;
  logic want_brk, st_pre, st_brk, st_dat;

  assign te_rise   = tx_en & ~te_q;
  assign brk_fall  = brk_q & ~brk_req;
  assign last_bit  = busy & (cnt_q == CW'(1));
  assign slot_free = ~busy | last_bit;
  assign go        = bit_tick & tx_en & te_q & ~dly_q & slot_free;
  assign want_brk  = brk_pend | brk_req | brk_fall;
  assign st_pre    = go & pre_pend;
  assign st_brk    = go & ~pre_pend & want_brk;
  assign st_dat    = go & ~pre_pend & ~want_brk & hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_q  <= 1'b0;
      brk_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      te_q  <= tx_en;
      brk_q <= brk_req;
      if (te_rise)       dly_q <= ~bit_tick;
      else if (bit_tick) dly_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_pend <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      if (st_pre)                pre_pend <= 1'b0;
      else if (te_rise && busy)  pre_pend <= 1'b1;
      if (st_brk)                brk_pend <= 1'b0;
      else if (brk_fall)         brk_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (st_dat) hold_full <= 1'b0;
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (st_pre) begin
      busy  <= 1'b1;
      sh_q  <= '1;
      cnt_q <= CW'(FRAME_BITS);
    end else if (st_brk) begin
      busy  <= 1'b1;
      sh_q  <= {1'b1, {(BRK_BITS-1){1'b0}}};
      cnt_q <= CW'(BRK_BITS);
    end else if (st_dat) begin
      busy  <= 1'b1;
      sh_q  <= {{(BRK_BITS-FRAME_BITS){1'b1}}, 1'b1, hold_q, 1'b0};
      cnt_q <= CW'(FRAME_BITS);
    end else if (bit_tick && busy) begin
      if (last_bit) begin
        busy <= 1'b0;
        sh_q <= '1;
      end else begin
        sh_q  <= {1'b1, sh_q[BRK_BITS-1:1]};
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign txd        = busy ? sh_q[0] : 1'b1;
  assign txd_oe     = tx_en | rx_active | busy;
  assign hold_empty = ~hold_full;
  assign tx_done    = ~busy & ~hold_full & ~pre_pend & ~brk_pend & ~brk_req;

endmodule

module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_en,
  input logic tx_en,
  input logic rx_active,
  input logic txd,
  input logic txd_oe,
  input logic hold_empty,
  input logic tx_done
);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (txd && hold_empty));

  assert_oe_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !rx_active && tx_done) |-> !txd_oe);

  assert_oe_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_active) |-> txd_oe);

  assert_start_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && tx_done) |=> txd);

endmodule

bind uart_tx_brk uart_tx_brk_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
  .tx_en(tx_en), .rx_active(rx_active), .txd(txd), .txd_oe(txd_oe),
  .hold_empty(hold_empty), .tx_done(tx_done)
);

// File: tb/uart_tx_brk_test.sv
module uart_tx_brk_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bit_tick, wr_en, tx_en, brk_req, rx_active;
  logic [7:0] wr_data;
  logic txd, txd_oe, hold_empty, tx_done;
  logic [1:0] div;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  logic last_tick = 1'b0;
  bit cap[$];
  bit expq[$];

  uart_tx_brk uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .tx_en(tx_en), .brk_req(brk_req), .rx_active(rx_active),
    .txd(txd), .txd_oe(txd_oe), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  always @(posedge clk) begin
    if (!rst_n) div <= 2'd0;
    else        div <= div + 2'd1;
  end
  assign bit_tick = rst_n && (div == 2'd3);

  always @(posedge clk) last_tick <= bit_tick;
  always @(negedge clk) if (last_tick) begin
    cap.push_back(txd);
    tick_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; i++) begin
      int t = tick_cnt;
      wait (tick_cnt != t);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_data = b;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic void add_frame(input logic [7:0] b);
    expq.push_back(1'b0);
    for (int i = 0; i < 8; i++) expq.push_back(b[i]);
    expq.push_back(1'b1);
  endfunction

  function automatic void add_bits(input bit v, input int n);
    for (int i = 0; i < n; i++) expq.push_back(v);
  endfunction

  function automatic void add_break();
    add_bits(1'b0, 10);
    add_bits(1'b1, 1);
  endfunction

  task automatic fresh();
    cap.delete();
    expq.delete();
  endtask

  task automatic cmp_stream(input string tag);
    int bad = -1;
    for (int i = 0; i < expq.size(); i++) begin
      if (bad < 0 && (i >= cap.size() || cap[i] != expq[i])) bad = i;
    end
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s bit %0d", tag, bad),
               (bad < cap.size()) ? int'(cap[bad]) : -1, int'(expq[bad]));
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; tx_en = 1'b0;
    brk_req = 1'b0; rx_active = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R10 txd", txd, 1);
    check(hold_empty == 1'b1, "R10 hold_empty", hold_empty, 1);
    check(tx_done == 1'b1, "R10 tx_done", tx_done, 1);
    check(txd_oe == 1'b0, "R10 R9 txd_oe off", txd_oe, 0);
    rx_active = 1'b1;
    @(negedge clk);
    check(txd_oe == 1'b1, "R9 oe with receiver", txd_oe, 1);
    rx_active = 1'b0;

    // cold enable with a byte: one idle bit, then the frame
    tick_wait(1); fresh();
    tx_en = 1'b1;
    wr(8'hA5);
    check(hold_empty == 1'b0, "R2 write fills", hold_empty, 0);
    tick_wait(1);
    check(txd == 1'b1, "R3 idle first tick", txd, 1);
    check(hold_empty == 1'b0, "R3 no transfer yet", hold_empty, 0);
    tick_wait(1);
    check(txd == 1'b0, "R3 start at second tick", txd, 0);
    check(hold_empty == 1'b1, "R2 transfer empties", hold_empty, 1);
    tick_wait(12);
    add_bits(1'b1, 1); add_frame(8'hA5); add_bits(1'b1, 3);
    cmp_stream("R1 R3 cold frame");
    check(tx_done == 1'b1, "R8 done after frame", tx_done, 1);

    // random back-to-back bytes
    void'($urandom(32'd2024));
    tick_wait(1); fresh();
    for (int k = 0; k < 20; k++) begin
      b = 8'($urandom);
      wr(b);
      add_frame(b);
      check(tx_done == 1'b0, "R8 busy with data", tx_done, 0);
      while (!hold_empty) tick_wait(1);
    end
    tick_wait(16);
    add_bits(1'b1, 5);
    cmp_stream("R1 random back-to-back");

    // enable dip during a word: preamble before next byte
    tick_wait(1); fresh();
    wr(8'h3C);
    tick_wait(1);
    tx_en = 1'b0;
    @(negedge clk);
    tx_en = 1'b1;
    wr(8'hC3);
    tick_wait(33);
    add_frame(8'h3C); add_bits(1'b1, 10); add_frame(8'hC3); add_bits(1'b1, 3);
    cmp_stream("R5 preamble");
    check(tx_done == 1'b1, "R8 done after preamble", tx_done, 1);

    // short break pulse: one break word before the waiting byte
    tick_wait(1); fresh();
    wr(8'h81);
    tick_wait(1);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    wr(8'h7E);
    tick_wait(34);
    add_frame(8'h81); add_break(); add_frame(8'h7E); add_bits(1'b1, 3);
    cmp_stream("R7 single break");

    // held break: repeated words, then exactly one more after release
    tick_wait(1); fresh();
    brk_req = 1'b1;
    tick_wait(22);
    brk_req = 1'b0;
    check(tx_done == 1'b0, "R8 break pending", tx_done, 0);
    tick_wait(23);
    add_break(); add_break(); add_break(); add_bits(1'b1, 12);
    cmp_stream("R6 R7 held break");
    check(tx_done == 1'b1, "R8 done after break", tx_done, 1);

    // enable dropped for good mid-word
    tick_wait(1); fresh();
    wr(8'h5A);
    tick_wait(1);
    tx_en = 1'b0;
    wr(8'h96);
    tick_wait(14);
    add_frame(8'h5A); add_bits(1'b1, 4);
    cmp_stream("R4 word completes");
    check(hold_empty == 1'b0, "R4 byte held back", hold_empty, 0);
    check(tx_done == 1'b0, "R8 not done with byte", tx_done, 0);
    check(txd_oe == 1'b0, "R9 released", txd_oe, 0);
    fresh();
    tx_en = 1'b1;
    tick_wait(14);
    add_bits(1'b1, 1); add_frame(8'h96); add_bits(1'b1, 3);
    cmp_stream("R3 R4 resumed");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule